// File: doc/BRIEF.md
# Timer Input Capture Unit

The unit watches one external input line and, when a qualifying transition arrives, copies the present value of a free-running 16-bit timer into a capture register. Two timers are presented to it, and a select input decides which one is copied. A 4-bit mode field picks the qualifying event: each falling transition, each rising transition, each fourth rising transition or each sixteenth rising transition. Any other mode value switches capture off. Every capture raises an interrupt-request flag. Only software clears the flag. A newer capture overwrites an unread value without any warning. Software may write the capture register as two separate bytes.

The input passes through a two-stage synchronizer. An edge detector then compares the newest synchronized sample with the one before it. When the line is driven as an output, the unit samples the port output value in place of the pad, so a write to the port that makes a qualifying transition also captures. A controller with three states sequences the mode. ST_OFF is the state with capture disabled. ST_SETTLE lasts one cycle after a change to a different capture mode; in that cycle the unit makes one spurious capture, which software masks by keeping the interrupt enable low during the change. ST_WATCH is the state that counts qualifying edges. The transitions are as follows:
- From any state, a write of a non-capture mode goes to ST_OFF.
- From any state, a write of a capture mode that differs from the current mode goes to ST_SETTLE.
- A write of the mode already held goes to ST_WATCH.
- ST_SETTLE with no write goes to ST_WATCH.
- ST_OFF and ST_WATCH with no write stay where they are.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset the capture register is 0, the flag is 0 and the mode readback is 4'b0000.
- R2: In mode 4'b0100, each falling transition of the sampled line loads the selected timer into the capture register, and rising transitions have no effect. The register takes the timer value held in the cycle before the third clock edge after the line changes.
- R3: In mode 4'b0101, each rising transition of the sampled line captures, with the same latency as in R2, and falling transitions have no effect.
- R4: In mode 4'b0110, the unit captures on the 4th, 8th, ... rising transition. In mode 4'b0111, it captures on the 16th, 32nd, ... rising transition. Rising transitions are counted from the last mode write.
- R5: A mode value outside 4'b0100..4'b0111 makes no capture and does not set the flag, whatever the line does.
- R6: With tmr_sel=0 the unit captures tmr_a, and with tmr_sel=1 it captures tmr_b.
- R7: Each capture sets the flag. The flag stays set until a flag_clr pulse. When flag_clr and a capture fall in the same cycle, the flag stays set.
- R8: A second capture replaces an unread captured value, and the flag simply stays set.
- R9: cap_lo_wr writes cap_wdata into bits 7:0 of the capture register, and cap_hi_wr writes it into bits 15:8. When a byte write and a capture fall in the same cycle, the capture wins.
- R10: A mode write of a capture mode that differs from the current mode makes exactly one capture and sets the flag, one clock edge after the write edge. A write of the mode already held, or of a non-capture mode, makes no such capture.
- R11: While pin_oe=1 the unit samples port_out and ignores cap_pin.
- R12: Every mode write restarts the rising-transition count, including a write of the mode already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | External capture line (pad level) |
| pin_oe | input | 1 | Line driven as output; sample port_out instead |
| port_out | input | 1 | Port output latch value for the line |
| tmr_a | input | 16 | Timer source 0 |
| tmr_b | input | 16 | Timer source 1 |
| tmr_sel | input | 1 | Timer source select |
| mode_wr | input | 1 | Mode field write strobe |
| mode_wdata | input | 4 | Mode field write value |
| mode_o | output | 4 | Current mode field |
| cap_lo_wr | input | 1 | Write low byte of capture register |
| cap_hi_wr | input | 1 | Write high byte of capture register |
| cap_wdata | input | 8 | Byte write data |
| cap_o | output | 16 | Capture register |
| flag_clr | input | 1 | Software clear of the interrupt-request flag |
| flag_o | output | 1 | Interrupt-request flag |

## Verification
Two pairs of functions can fall in the same cycle: a capture with a byte write to the capture register, and a capture with a flag clear. The bench counts the synchronizer stages, then raises both byte strobes and flag_clr in exactly the cycle in which the detected edge fires. It expects the timer value in the capture register and a set flag. Sweeps over all non-capture mode values and long runs of rising transitions in the divided modes check the prescaler against counts worked out arithmetically in the bench.

// File: rtl/capu_pkg.sv
package capu_pkg;
    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] MD_OFF    = 4'b0000;
    localparam logic [MODE_W-1:0] MD_FALL   = 4'b0100;
    localparam logic [MODE_W-1:0] MD_RISE   = 4'b0101;
    localparam logic [MODE_W-1:0] MD_RISE4  = 4'b0110;
    localparam logic [MODE_W-1:0] MD_RISE16 = 4'b0111;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_WATCH  = 2'd2
    } capu_state_e;

    typedef enum logic [1:0] {
        DIV_ONE = 2'd0,
        DIV_A   = 2'd1,
        DIV_B   = 2'd2
    } capu_div_e;

    function automatic logic mode_is_cap(input logic [MODE_W-1:0] m);
        return m[3:2] == 2'b01;
    endfunction
endpackage

// File: rtl/capu_sync_edge.sv
module capu_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~prev;
    assign fall = ~chain[STAGES-1] & prev;

    // R3
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    // R2
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/capu_prescale.sv
module capu_prescale #(
    parameter int DIVA = 4,
    parameter int DIVB = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       evt,
    input  logic [1:0] div_sel,
    output logic       fire
);
    import capu_pkg::*;
    localparam int CW = $clog2(DIVB);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    always_comb begin
        unique case (capu_div_e'(div_sel))
            DIV_A:   limit = CW'(DIVA - 1);
            DIV_B:   limit = CW'(DIVB - 1);
            default: limit = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (clr)           cnt <= '0;
        else if (evt) begin
            if (cnt == limit)   cnt <= '0;
            else                cnt <= cnt + 1'b1;
        end
    end

    assign fire = evt && !clr && (cnt == limit);

    // R4
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> cnt == '0);
    // R12
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);
endmodule

// File: rtl/capu_ctrl.sv
module capu_ctrl (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mode_wr,
    input  logic [capu_pkg::MODE_W-1:0]   mode_wdata,
    input  logic                          rise,
    input  logic                          fall,
    output logic [capu_pkg::MODE_W-1:0]   mode_q,
    output logic                          glitch,
    output logic                          evt,
    output logic                          pre_clr,
    output logic [1:0]                    div_sel
);
    import capu_pkg::*;

    capu_state_e state, nxt;
    logic        watching;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_OFF;
            mode_q <= MD_OFF;
        end else begin
            state <= nxt;
            if (mode_wr) mode_q <= mode_wdata;
        end
    end

    always_comb begin
        unique case (state)
            ST_OFF:    nxt = ST_OFF;
            ST_SETTLE: nxt = ST_WATCH;
            ST_WATCH:  nxt = ST_WATCH;
            default:   nxt = ST_OFF;
        endcase
        if (mode_wr) begin
            if (!mode_is_cap(mode_wdata))  nxt = ST_OFF;
            else if (mode_wdata != mode_q) nxt = ST_SETTLE;
            else                           nxt = ST_WATCH;
        end
    end

    always_comb begin
        glitch   = 1'b0;
        watching = 1'b0;
        unique case (state)
            ST_OFF:    ;
            ST_SETTLE: glitch = 1'b1;
            ST_WATCH:  watching = 1'b1;
            default:   ;
        endcase
        pre_clr = mode_wr | ~watching;
        evt     = watching & ~mode_wr & ((mode_q == MD_FALL) ? fall : rise);
        unique case (mode_q)
            MD_RISE4:  div_sel = 2'(DIV_A);
            MD_RISE16: div_sel = 2'(DIV_B);
            default:   div_sel = 2'(DIV_ONE);
        endcase
    end

    // R10
    settle_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE) && !mode_wr |=> state == ST_WATCH);
    // R5
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> !evt && !glitch);
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit #(
    parameter int TMR_W  = 16,
    parameter int STAGES = 2,
    parameter int DIVA   = 4,
    parameter int DIVB   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cap_pin,
    input  logic                         pin_oe,
    input  logic                         port_out,
    input  logic [TMR_W-1:0]             tmr_a,
    input  logic [TMR_W-1:0]             tmr_b,
    input  logic                         tmr_sel,
    input  logic                         mode_wr,
    input  logic [capu_pkg::MODE_W-1:0]  mode_wdata,
    output logic [capu_pkg::MODE_W-1:0]  mode_o,
    input  logic                         cap_lo_wr,
    input  logic                         cap_hi_wr,
    input  logic [TMR_W/2-1:0]           cap_wdata,
    output logic [TMR_W-1:0]             cap_o,
    input  logic                         flag_clr,
    output logic                         flag_o
);
    localparam int HALF = TMR_W / 2;

    logic             pin_lvl, rise, fall;
    logic             glitch, evt, pre_clr, pre_fire, cap_fire;
    logic [1:0]       div_sel;
    logic [TMR_W-1:0] tmr_mux, cap_q;
    logic             flag_q;

    assign pin_lvl = pin_oe ? port_out : cap_pin;

    capu_sync_edge #(.STAGES(STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .din(pin_lvl), .rise(rise), .fall(fall)
    );

    capu_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .rise(rise), .fall(fall), .mode_q(mode_o), .glitch(glitch),
        .evt(evt), .pre_clr(pre_clr), .div_sel(div_sel)
    );

    capu_prescale #(.DIVA(DIVA), .DIVB(DIVB)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(pre_clr), .evt(evt),
        .div_sel(div_sel), .fire(pre_fire)
    );

    assign tmr_mux  = tmr_sel ? tmr_b : tmr_a;
    assign cap_fire = glitch | pre_fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (cap_fire) begin
            cap_q <= tmr_mux;
        end else begin
            if (cap_lo_wr) cap_q[HALF-1:0]     <= cap_wdata;
            if (cap_hi_wr) cap_q[TMR_W-1:HALF] <= cap_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (cap_fire) flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign cap_o  = cap_q;
    assign flag_o = flag_q;

    // R9
    cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> cap_q == $past(tmr_mux));
    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> flag_q);
    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q && !flag_clr |=> flag_q);
    // R7
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(cap_fire));
endmodule

// File: tb/edge_capture_unit_tb.sv
module edge_capture_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_pin = 1'b0, pin_oe = 1'b0, port_out = 1'b0;
    logic [15:0] tmr_a = '0, tmr_b = '0;
    logic        tmr_sel = 1'b0;
    logic        mode_wr = 1'b0;
    logic [3:0]  mode_wdata = '0;
    logic [3:0]  mode_o;
    logic        cap_lo_wr = 1'b0, cap_hi_wr = 1'b0;
    logic [7:0]  cap_wdata = '0;
    logic [15:0] cap_o;
    logic        flag_clr = 1'b0;
    logic        flag_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] exp_cap = '0;

    always #5 clk = ~clk;

    edge_capture_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .pin_oe(pin_oe),
        .port_out(port_out), .tmr_a(tmr_a), .tmr_b(tmr_b), .tmr_sel(tmr_sel),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata), .mode_o(mode_o),
        .cap_lo_wr(cap_lo_wr), .cap_hi_wr(cap_hi_wr), .cap_wdata(cap_wdata),
        .cap_o(cap_o), .flag_clr(flag_clr), .flag_o(flag_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk) cap_pin = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_port(input logic v);
        @(negedge clk) port_out = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic write_mode(input logic [3:0] v);
        @(negedge clk) begin mode_wr = 1'b1; mode_wdata = v; end
        @(negedge clk) mode_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_flag();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 cap", cap_o, 16'h0);
        chk("R1 flag", {15'b0, flag_o}, 16'h0);
        chk("R1 mode", {12'b0, mode_o}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 sweep of every non-capture mode value
        for (int v = 0; v < 16; v++) begin
            if (v >= 4 && v <= 7) continue;
            tmr_a = 16'hE000 + 16'(v);
            write_mode(4'(v));
            chk("R5 mode readback", {12'b0, mode_o}, 16'(v));
            set_pin(1'b1);
            set_pin(1'b0);
            chk("R5 cap", cap_o, exp_cap);
            chk("R5 flag", {15'b0, flag_o}, 16'h0);
        end

        // R10 spurious capture on entering rising mode
        tmr_a = 16'h0A55;
        write_mode(4'b0101);
        exp_cap = 16'h0A55;
        chk("R10 spurious cap", cap_o, exp_cap);
        chk("R10 spurious flag", {15'b0, flag_o}, 16'h1);
        clear_flag();
        chk("R7 flag cleared", {15'b0, flag_o}, 16'h0);

        // R3 rising mode
        for (int i = 0; i < 4; i++) begin
            tmr_a = 16'h1000 + 16'(i);
            set_pin(1'b1);
            exp_cap = tmr_a;
            chk("R3 rise cap", cap_o, exp_cap);
            chk("R7 flag set", {15'b0, flag_o}, 16'h1);
            clear_flag();
            tmr_a = 16'h1F00 + 16'(i);
            set_pin(1'b0);
            chk("R3 fall ignored cap", cap_o, exp_cap);
            chk("R3 fall ignored flag", {15'b0, flag_o}, 16'h0);
        end

        // R2 falling mode
        tmr_a = 16'h3300;
        write_mode(4'b0100);
        exp_cap = 16'h3300;
        chk("R10 spurious fall cap", cap_o, exp_cap);
        clear_flag();
        tmr_a = 16'h3301;
        set_pin(1'b1);
        chk("R2 rise ignored", cap_o, exp_cap);
        chk("R2 rise ignored flag", {15'b0, flag_o}, 16'h0);
        set_pin(1'b0);
        exp_cap = 16'h3301;
        chk("R2 fall cap", cap_o, exp_cap);

        // R4 divide by 4
        tmr_a = 16'h4000;
        write_mode(4'b0110);
        exp_cap = 16'h4000;
        chk("R10 spurious div4", cap_o, exp_cap);
        for (int n = 1; n <= 9; n++) begin
            tmr_a = 16'h4000 + 16'(n);
            set_pin(1'b1);
            set_pin(1'b0);
            if (n % 4 == 0) exp_cap = tmr_a;
            chk("R4 div4", cap_o, exp_cap);
        end

        // R4 divide by 16
        tmr_a = 16'h6000;
        write_mode(4'b0111);
        exp_cap = 16'h6000;
        for (int n = 1; n <= 33; n++) begin
            tmr_a = 16'h6000 + 16'(n);
            set_pin(1'b1);
            set_pin(1'b0);
            if (n % 16 == 0) exp_cap = tmr_a;
            chk("R4 div16", cap_o, exp_cap);
        end

        // R12 rewrite of the same mode restarts the count, R10 no spurious
        tmr_a = 16'h6800;
        write_mode(4'b0110);
        exp_cap = 16'h6800;
        for (int n = 1; n <= 2; n++) begin
            tmr_a = 16'h6810 + 16'(n);
            set_pin(1'b1);
            set_pin(1'b0);
        end
        clear_flag();
        tmr_a = 16'h6900;
        write_mode(4'b0110);
        chk("R10 same mode no capture", cap_o, exp_cap);
        chk("R10 same mode no flag", {15'b0, flag_o}, 16'h0);
        for (int n = 1; n <= 4; n++) begin
            tmr_a = 16'h6A00 + 16'(n);
            set_pin(1'b1);
            set_pin(1'b0);
            if (n == 4) exp_cap = tmr_a;
            chk("R12 restart count", cap_o, exp_cap);
        end

        // R6 timer select
        tmr_sel = 1'b1;
        tmr_a = 16'h1111;
        tmr_b = 16'hBEEF;
        write_mode(4'b0101);
        exp_cap = 16'hBEEF;
        chk("R6 select b spurious", cap_o, exp_cap);
        tmr_b = 16'hCAFE;
        set_pin(1'b1);
        exp_cap = 16'hCAFE;
        chk("R6 select b", cap_o, exp_cap);
        set_pin(1'b0);
        tmr_sel = 1'b0;

        // R8 overwrite of unread value
        clear_flag();
        tmr_a = 16'h5A01;
        set_pin(1'b1);
        set_pin(1'b0);
        tmr_a = 16'h5A02;
        set_pin(1'b1);
        set_pin(1'b0);
        exp_cap = 16'h5A02;
        chk("R8 overwrite", cap_o, exp_cap);
        chk("R8 flag set", {15'b0, flag_o}, 16'h1);

        // R9 byte writes
        @(negedge clk) begin cap_lo_wr = 1'b1; cap_wdata = 8'h34; end
        @(negedge clk) cap_lo_wr = 1'b0;
        exp_cap = {exp_cap[15:8], 8'h34};
        chk("R9 low byte", cap_o, exp_cap);
        @(negedge clk) begin cap_hi_wr = 1'b1; cap_wdata = 8'h12; end
        @(negedge clk) cap_hi_wr = 1'b0;
        exp_cap = 16'h1234;
        chk("R9 high byte", cap_o, exp_cap);

        // R9 and R7 collision with a capture in the same cycle
        clear_flag();
        tmr_a = 16'h7E7E;
        @(negedge clk) cap_pin = 1'b1;
        @(negedge clk);
        @(negedge clk) begin
            cap_lo_wr = 1'b1; cap_hi_wr = 1'b1; cap_wdata = 8'h00; flag_clr = 1'b1;
        end
        @(negedge clk) begin
            cap_lo_wr = 1'b0; cap_hi_wr = 1'b0; flag_clr = 1'b0;
        end
        exp_cap = 16'h7E7E;
        chk("R9 capture beats write", cap_o, exp_cap);
        chk("R7 capture beats clear", {15'b0, flag_o}, 16'h1);
        set_pin(1'b0);
        clear_flag();

        // R11 output-driven line
        pin_oe = 1'b1;
        tmr_a = 16'h9090;
        set_pin(1'b1);
        chk("R11 pad ignored", cap_o, exp_cap);
        chk("R11 pad ignored flag", {15'b0, flag_o}, 16'h0);
        set_pin(1'b0);
        tmr_a = 16'h9191;
        set_port(1'b1);
        exp_cap = 16'h9191;
        chk("R11 port write captures", cap_o, exp_cap);
        set_port(1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule